// File: doc/BRIEF.md
# Snapshot Statistics Counter Bank

This block keeps a bank of per-event MAC statistics counters. Each counter is 40 bits wide. An upstream frame engine drives one strobe per counter. Most counters add one per strobe. Octet counters add a per-event byte count of up to 16 bits instead.

Software never reads the live counters. It writes a snap command, which copies every live counter into a shadow register in one cycle. It then reads the frozen values in 16-bit words at its own pace, while the live counters keep counting.

A counter that wraps past its all-ones value raises a sticky flag. The flags are packed into four 16-bit registers that clear when read. Software can therefore extend the 40-bit hardware counts in its own memory. A clear command zeroes the live counters, the shadows and the flags.

Top module: `stats_snap_bank`

## Requirements
- R1: After reset all live counters, shadow registers and wrap flags are zero, and `reg_rdata` is 0.
- R2: A counter that is not an octet counter adds exactly 1 for each clock cycle its `evt_valid` bit is high, and holds its value otherwise.
- R3: An octet counter (selected by a set bit in `OCTET_MASK`) adds its `evt_bytes` lane on each strobe. Counters that are not octet counters ignore their `evt_bytes` lane.
- R4: Counter i is read at address `CNT_BASE + 4*i`. Word offset 0 returns bits 15:0. Offset 1 returns bits 31:16. Offset 2 returns bits 39:32 in its low byte, with the high byte zero. Offset 3 returns 0.
- R5: Writing 1 to bit 0 of the control register (address 0) copies all live counters into the shadows in the same edge. The shadows then hold their values until the next snap or clear, while the live counters continue.
- R6: An event in the same cycle as a snap goes into the live count only. The shadow takes the count from before that event.
- R7: Writing 1 to bit 1 of the control register zeroes all live counters, shadows and wrap flags. Events in that cycle are dropped. A clear takes precedence over a snap in the same write.
- R8: When counter i wraps past 2^CNT_W - 1, wrap flag i is set. Flag i sits in wrap register i/16 (addresses 4 to 7), at bit i%16.
- R9: Reading a wrap register returns the flags as they stood before the read. It then clears only that register's 16 flags.
- R10: If a counter wraps in the same cycle its wrap register is read, its flag stays set.
- R11: Read data appears on `reg_rdata` at the clock edge that samples `reg_rd`. It holds until the next read. Addresses outside the control, wrap and counter ranges read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | NUM_CNT | One event strobe per counter |
| evt_bytes | input | NUM_CNT x INC_W | Byte count per counter, used by octet counters |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 16 | Write data; bit 0 snap, bit 1 clear |
| reg_rdata | output | 16 | Registered read data |

## Verification
Unit strobes, large and small byte counts, and strobes on counters that are not octet counters are each read back through a snapshot. This separates the increment paths and shows which lanes are ignored.

A run of 65540 maximum-size byte events pushes an octet counter past 2^32, so all three read words carry distinct data.

Events placed after a snap, inside a snap cycle and inside a clear cycle show whether the shadows are atomic and where an event lands. A second instance with narrow counters reaches real wraps. It checks flag placement across two wrap registers, clearing of one word only, and a wrap that coincides with the read of its flag.

// File: rtl/stats_bank_pkg.sv
`timescale 1ns/1ps
package stats_bank_pkg;

    localparam int REG_W      = 16;
    localparam int ROLL_WORDS = 4;
    localparam int EXT_W      = 48;

    // Select one 16-bit word of a zero-extended counter value
    function automatic logic [REG_W-1:0] cnt_word(input logic [EXT_W-1:0] v,
                                                  input logic [1:0] w);
        case (w)
            2'd0:    return v[15:0];
            2'd1:    return v[31:16];
            2'd2:    return {8'h00, v[39:32]};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/stats_live_ctr.sv
`timescale 1ns/1ps
module stats_live_ctr #(
    parameter int CNT_W    = 40,
    parameter int INC_W    = 16,
    parameter bit IS_OCTET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic [INC_W-1:0] bytes,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);

    localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t          st_d, st_q;
    logic [SUM_W-1:0] inc_d;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        st_d  = st_q;
        wrap  = 1'b0;
        inc_d = IS_OCTET ? SUM_W'(bytes) : SUM_W'(1);
        sum_d = SUM_W'(st_q.cnt) + inc_d;
        if (clr) begin
            st_d.cnt = '0;
        end else if (evt) begin
            st_d.cnt = sum_d[CNT_W-1:0];
            wrap     = |(sum_d >> CNT_W);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt) |=> $stable(cnt_q)); // R2
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R7

    generate
        if (!IS_OCTET) begin : g_unit
            AST_UNIT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                wrap |=> (cnt_q == '0)); // R8
        end
    endgenerate

endmodule

// File: rtl/stats_wrap_flags.sv
`timescale 1ns/1ps
module stats_wrap_flags #(
    parameter int NUM_CNT = 8,
    parameter int RW      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_CNT-1:0]   wrap,
    input  logic [RW-1:0]        rd_word,
    output logic [RW*16-1:0]     flags_q
);

    localparam int FW = RW * 16;

    typedef struct packed {
        logic [FW-1:0] f;
    } flag_st_t;

    flag_st_t      st_d, st_q;
    logic [FW-1:0] rd_mask;

    always_comb begin
        rd_mask = '0;
        for (int k = 0; k < RW; k++) begin
            if (rd_word[k]) rd_mask[k*16 +: 16] = '1;
        end
        st_d = st_q;
        if (clr) st_d.f = '0;
        else     st_d.f = (st_q.f & ~rd_mask) | FW'(wrap);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.f;

    AST_WRAP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap) |=> ((flags_q[NUM_CNT-1:0] & $past(wrap)) == $past(wrap))); // R10
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags_q == '0)); // R7

    generate
        for (genvar k = 0; k < RW; k++) begin : g_word
            AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_word[k] && !clr && (wrap == '0)) |=> (flags_q[k*16 +: 16] == '0)); // R9
        end
    endgenerate

endmodule

// File: rtl/stats_snap_bank.sv
`timescale 1ns/1ps
module stats_snap_bank
    import stats_bank_pkg::*;
#(
    parameter int          NUM_CNT    = 8,
    parameter int          CNT_W      = 40,
    parameter int          INC_W      = 16,
    parameter int          ADDR_W     = 8,
    parameter logic [63:0] OCTET_MASK = 64'h1,
    parameter int          CTRL_ADDR  = 0,
    parameter int          ROLL_BASE  = 4,
    parameter int          CNT_BASE   = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CNT-1:0]                evt_valid,
    input  logic [NUM_CNT-1:0][INC_W-1:0]     evt_bytes,
    input  logic                              reg_wr,
    input  logic                              reg_rd,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [REG_W-1:0]                  reg_wdata,
    output logic [REG_W-1:0]                  reg_rdata
);

    localparam int FW    = ROLL_WORDS * 16;
    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] shadow;
        logic [REG_W-1:0]              rdata;
    } bank_st_t;

    bank_st_t                      st_d, st_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] live;
    logic [NUM_CNT-1:0]            wrap_v;
    logic [FW-1:0]                 flags;
    logic [ROLL_WORDS-1:0]         rd_word;
    logic                          ctrl_hit, clr_cmd, snap_cmd;
    logic [ADDR_W-1:0]             cnt_off;
    logic [IDX_W-1:0]              cnt_idx;
    logic [1:0]                    cnt_wsel;
    logic                          cnt_hit;
    logic [CNT_W-1:0]              cnt_sel;
    logic                          unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:2];

    // Command and address decode
    always_comb begin
        ctrl_hit = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
        clr_cmd  = ctrl_hit && reg_wdata[1];
        snap_cmd = ctrl_hit && reg_wdata[0] && !reg_wdata[1];
        for (int k = 0; k < ROLL_WORDS; k++) begin
            rd_word[k] = reg_rd && (reg_addr == ADDR_W'(ROLL_BASE + k));
        end
        cnt_off  = reg_addr - ADDR_W'(CNT_BASE);
        cnt_idx  = cnt_off[ADDR_W-1:2];
        cnt_wsel = cnt_off[1:0];
        cnt_hit  = (reg_addr >= ADDR_W'(CNT_BASE)) && (32'(cnt_idx) < NUM_CNT);
        cnt_sel  = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (32'(cnt_idx) == i) cnt_sel = st_q.shadow[i];
        end
    end

    // Live counters, one per event
    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_ctr
            stats_live_ctr #(
                .CNT_W    (CNT_W),
                .INC_W    (INC_W),
                .IS_OCTET (OCTET_MASK[i])
            ) u_ctr (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr_cmd),
                .evt   (evt_valid[i]),
                .bytes (evt_bytes[i]),
                .cnt_q (live[i]),
                .wrap  (wrap_v[i])
            );
        end
    endgenerate

    stats_wrap_flags #(
        .NUM_CNT (NUM_CNT),
        .RW      (ROLL_WORDS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_cmd),
        .wrap    (wrap_v),
        .rd_word (rd_word),
        .flags_q (flags)
    );

    // Shadow copy and read port
    always_comb begin
        st_d = st_q;
        if (clr_cmd)       st_d.shadow = '0;
        else if (snap_cmd) st_d.shadow = live;
        if (reg_rd) begin
            st_d.rdata = '0;
            for (int k = 0; k < ROLL_WORDS; k++) begin
                if (rd_word[k]) st_d.rdata = flags[k*16 +: 16];
            end
            if (cnt_hit) st_d.rdata = cnt_word(EXT_W'(cnt_sel), cnt_wsel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    AST_SNAP_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cmd |=> (st_q.shadow == $past(live))); // R5
    AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!snap_cmd && !clr_cmd) |=> $stable(st_q.shadow)); // R5
    AST_CLEAR_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (st_q.shadow == '0)); // R7
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R11

endmodule

// File: tb/tb_stats_snap_bank.sv
`timescale 1ns/1ps
module tb_stats_snap_bank;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic rst_n;

    logic [7:0]        evt_a;
    logic [7:0][15:0]  byt_a;
    logic              wr_a, rd_a;
    logic [7:0]        addr_a;
    logic [15:0]       wd_a, rdata_a;

    logic [19:0]       evt_b;
    logic [19:0][15:0] byt_b;
    logic              wr_b, rd_b;
    logic [7:0]        addr_b;
    logic [15:0]       wd_b, rdata_b;

    int checks = 0;
    int errors = 0;

    stats_snap_bank dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_a), .evt_bytes(byt_a),
        .reg_wr(wr_a), .reg_rd(rd_a), .reg_addr(addr_a), .reg_wdata(wd_a),
        .reg_rdata(rdata_a));

    stats_snap_bank #(.NUM_CNT(20), .CNT_W(10), .OCTET_MASK(64'h20001)) dut_small (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_b), .evt_bytes(byt_b),
        .reg_wr(wr_b), .reg_rd(rd_b), .reg_addr(addr_b), .reg_wdata(wd_b),
        .reg_rdata(rdata_b));

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_read(input bit sel, input int addr, output logic [15:0] d);
        @(negedge clk);
        if (sel) begin rd_b = 1'b1; addr_b = 8'(addr); end
        else     begin rd_a = 1'b1; addr_a = 8'(addr); end
        @(negedge clk);
        rd_a = 1'b0; rd_b = 1'b0;
        d = sel ? rdata_b : rdata_a;
    endtask

    task automatic ctrl_write(input bit sel, input logic [15:0] v);
        @(negedge clk);
        if (sel) begin wr_b = 1'b1; addr_b = 8'h00; wd_b = v; end
        else     begin wr_a = 1'b1; addr_a = 8'h00; wd_a = v; end
        @(negedge clk);
        wr_a = 1'b0; wr_b = 1'b0;
    endtask

    task automatic pulse(input bit sel, input int idx, input int nbytes, input int n);
        @(negedge clk);
        if (sel) begin evt_b[idx] = 1'b1; byt_b[idx] = 16'(nbytes); end
        else     begin evt_a[idx] = 1'b1; byt_a[idx] = 16'(nbytes); end
        repeat (n) @(posedge clk);
        @(negedge clk);
        evt_a = '0; evt_b = '0;
    endtask

    task automatic read_cnt(input bit sel, input int idx, output longint unsigned v);
        logic [15:0] w0, w1, w2;
        reg_read(sel, 64 + 4*idx, w0);
        reg_read(sel, 64 + 4*idx + 1, w1);
        reg_read(sel, 64 + 4*idx + 2, w2);
        v = {24'h0, w2[7:0], w1, w0};
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R1", "rdata after reset", rdata_a, 0);
        reg_read(0, 64, d);
        check("R1", "counter0 word0 after reset", d, 0);
        reg_read(0, 4, d);
        check("R1", "wrap word0 after reset", d, 0);
    endtask

    task automatic t_count;
        longint unsigned v;
        pulse(0, 1, 0, 3);
        pulse(0, 2, 0, 1);
        pulse(0, 0, 100, 1);
        pulse(0, 0, 1500, 1);
        pulse(0, 5, 999, 2);
        ctrl_write(0, 16'h1);
        read_cnt(0, 1, v); check("R2", "counter1 after 3 strobes", v, 3);
        read_cnt(0, 2, v); check("R2", "counter2 after 1 strobe", v, 1);
        read_cnt(0, 3, v); check("R2", "idle counter3", v, 0);
        read_cnt(0, 0, v); check("R3", "octet counter0 100+1500", v, 1600);
        read_cnt(0, 5, v); check("R3", "unit counter5 ignores bytes", v, 2);
    endtask

    task automatic t_layout;
        logic [15:0] d;
        ctrl_write(0, 16'h2);
        pulse(0, 0, 65535, 65540);
        ctrl_write(0, 16'h1);
        reg_read(0, 64, d); check("R4", "word0", d, 16'hFFFC);
        reg_read(0, 65, d); check("R4", "word1", d, 16'h0002);
        reg_read(0, 66, d); check("R4", "word2 with zero high byte", d, 16'h0001);
        reg_read(0, 67, d); check("R4", "word3 reads zero", d, 0);
    endtask

    task automatic t_snap;
        longint unsigned v;
        ctrl_write(0, 16'h2);
        pulse(0, 1, 0, 2);
        ctrl_write(0, 16'h1);
        pulse(0, 1, 0, 3);
        read_cnt(0, 1, v); check("R5", "shadow frozen while live counts", v, 2);
        @(negedge clk);
        wr_a = 1'b1; addr_a = 8'h00; wd_a = 16'h1; evt_a[1] = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; evt_a = '0;
        read_cnt(0, 1, v); check("R6", "snap takes count before same-cycle event", v, 5);
        ctrl_write(0, 16'h1);
        read_cnt(0, 1, v); check("R6", "same-cycle event landed in live", v, 6);
    endtask

    task automatic t_clear;
        longint unsigned v;
        @(negedge clk);
        wr_a = 1'b1; addr_a = 8'h00; wd_a = 16'h3; evt_a[1] = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; evt_a = '0;
        read_cnt(0, 1, v); check("R7", "shadow zero after clear", v, 0);
        ctrl_write(0, 16'h1);
        read_cnt(0, 1, v); check("R7", "event in clear cycle dropped", v, 0);
        read_cnt(0, 0, v); check("R7", "octet counter cleared", v, 0);
    endtask

    task automatic t_wrap;
        logic [15:0] d;
        longint unsigned v;
        pulse(1, 1, 0, 1024);
        pulse(1, 17, 600, 2);
        reg_read(1, 5, d); check("R8", "wrap word1 bit for counter17", d, 16'h0002);
        reg_read(1, 4, d); check("R9", "word0 kept after word1 read", d, 16'h0002);
        reg_read(1, 4, d); check("R9", "word0 cleared by read", d, 0);
        reg_read(1, 5, d); check("R9", "word1 cleared by read", d, 0);
        ctrl_write(1, 16'h1);
        read_cnt(1, 1, v);  check("R8", "unit counter wrapped to zero", v, 0);
        read_cnt(1, 17, v); check("R8", "octet counter remainder", v, 176);
    endtask

    task automatic t_race;
        logic [15:0] d;
        pulse(1, 2, 0, 1023);
        @(negedge clk);
        evt_b[2] = 1'b1; rd_b = 1'b1; addr_b = 8'h04;
        @(negedge clk);
        evt_b = '0; rd_b = 1'b0;
        check("R10", "read shows flags before wrap", rdata_b, 0);
        reg_read(1, 4, d); check("R10", "flag survives same-cycle read", d, 16'h0004);
        pulse(1, 3, 0, 1024);
        ctrl_write(1, 16'h2);
        reg_read(1, 4, d); check("R7", "clear zeroes wrap flags", d, 0);
    endtask

    task automatic t_port;
        logic [15:0] d;
        pulse(0, 2, 0, 7);
        ctrl_write(0, 16'h1);
        reg_read(0, 64 + 8, d); check("R11", "counter2 word0", d, 7);
        repeat (3) @(negedge clk);
        check("R11", "rdata holds without read", rdata_a, 7);
        reg_read(0, 16, d); check("R11", "unmapped address reads zero", d, 0);
        reg_read(0, 64 + 4*8, d); check("R11", "counter index past bank reads zero", d, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        evt_a = '0; byt_a = '0; wr_a = 1'b0; rd_a = 1'b0; addr_a = '0; wd_a = '0;
        evt_b = '0; byt_b = '0; wr_b = 1'b0; rd_b = 1'b0; addr_b = '0; wd_b = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_count;
        t_layout;
        t_snap;
        t_clear;
        t_wrap;
        t_race;
        t_port;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule